// File: doc/BRIEF.md
# Secure RTC seconds counter

This block keeps time for a tamper-aware real-time clock. A single count, advanced by one on every pulse of a low-power tick (a clock-enable at 32.768 kHz in the target system), is split into a whole-seconds word in its upper bits and a sub-second fraction in its low bits. With the default sizes the count is 47 bits wide: 32 bits of seconds and 15 bits of fraction. A seconds-only alarm compares against the seconds word and raises a flag, and optionally an interrupt, once per match.

Counting is deliberately fragile. It stops when the count wraps, when the security monitor reports a non-valid or failure condition, or when software has not enabled it. It stays stopped until software clears the cause. Two sticky lock bits, a soft one and a hard one, freeze the time value and the enable bit against any rewrite until the next reset. Register writes arrive as one-cycle strobes that are already in the tick's clock domain.

Top module: `secure_rtc_counter`

## Requirements
- R1: While running, each `tick_i` pulse adds one to the combined count {`sec_o`,`frac_o`}, with the fraction as the low FRAC_W bits, so a fraction of all ones carries into the seconds.
- R2: After reset the count is zero, the alarm seconds are all ones, the overflow and alarm flags are clear, and the enable, interrupt-enable and both lock bits are clear.
- R3: `sec_wr_i` loads `wdata_i` into the seconds and `frac_wr_i` loads `wdata_i[FRAC_W-1:0]` into the fraction, each without touching the other part. In a cycle with an accepted write, a tick does not advance the count.
- R4: `alarm_irq_o` is high exactly when the alarm flag and the alarm interrupt enable (control bit 1) are both set.
- R5: The count holds while the enable (control bit 0) is clear, while the overflow flag is set, while `nonvalid_i` is high, or while `failure_i` is high.
- R6: The soft lock (control bit 2) and hard lock (control bit 3) can only be set by a control write, and are cleared only by reset. While either is set, seconds writes, fraction writes and changes to the enable bit are ignored. The interrupt enable stays writable.
- R7: A pulse on `ovf_clr_i` clears the overflow flag, after which an enabled, unfrozen counter counts again.
- R8: A tick that takes the count from all ones wraps it to zero and sets the overflow flag. The count then holds at zero.
- R9: The alarm flag sets on the tick whose new count has a zero fraction and seconds equal to the alarm seconds. This gives one set per match. `alarm_clr_i` clears the flag, and a set in the same cycle takes priority over the clear.
- R10: `alarm_wr_i` loads `wdata_i` into the alarm seconds whatever the lock state. A match in the same cycle compares against the old alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Low-power count enable pulse |
| nonvalid_i | input | 1 | Monitor reports time not valid; freezes count |
| failure_i | input | 1 | Monitor in failure state; freezes count |
| sec_wr_i | input | 1 | Seconds write strobe |
| frac_wr_i | input | 1 | Fraction write strobe |
| alarm_wr_i | input | 1 | Alarm seconds write strobe |
| ctrl_wr_i | input | 1 | Control write strobe |
| wdata_i | input | SEC_W | Write data for seconds, fraction (low bits) and alarm |
| ctrl_data_i | input | 4 | Control data: bit0 enable, bit1 alarm IRQ enable, bit2 soft lock, bit3 hard lock |
| ovf_clr_i | input | 1 | Overflow flag clear pulse |
| alarm_clr_i | input | 1 | Alarm flag clear pulse |
| sec_o | output | SEC_W | Seconds word |
| frac_o | output | FRAC_W | Sub-second fraction |
| alarm_o | output | SEC_W | Alarm seconds |
| ovf_o | output | 1 | Overflow flag |
| alarm_flag_o | output | 1 | Alarm flag |
| alarm_irq_o | output | 1 | Alarm interrupt |

## Verification
A wrong internal state shows up as a count that is off by one or more on the very next sampled cycle. The bench compares the count after every single stimulus cycle, so a missed or extra increment, a write that leaks through a lock, or a freeze that fails is caught within one cycle. Alarm errors appear as a flag that rises one tick early or late, or twice, during a full sweep of the count for every alarm value. A stuck overflow or lock bit shows as a count that never resumes or a write that is accepted.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  localparam int unsigned CTRL_W      = 4;
  localparam int unsigned CTRL_EN     = 0;
  localparam int unsigned CTRL_IE     = 1;
  localparam int unsigned CTRL_SLOCK  = 2;
  localparam int unsigned CTRL_HLOCK  = 3;
endpackage

// File: rtl/srtc_count_core.sv
module srtc_count_core #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              sec_we_i,
  input  logic              frac_we_i,
  input  logic [SEC_W-1:0]  wdata_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              wrap_o,
  output logic              roll_o,
  output logic [SEC_W-1:0]  next_sec_o
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  // count plus one, carry kept in the top bit
  function automatic logic [CNT_W:0] add_one(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   inc_w;

  assign inc_w      = add_one(cnt_q);
  assign wrap_o     = step_i & inc_w[CNT_W];
  assign roll_o     = step_i & (inc_w[FRAC_W-1:0] == '0);
  assign next_sec_o = inc_w[CNT_W-1:FRAC_W];
  assign sec_o      = cnt_q[CNT_W-1:FRAC_W];
  assign frac_o     = cnt_q[FRAC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (sec_we_i || frac_we_i) begin
      if (sec_we_i)  cnt_q[CNT_W-1:FRAC_W] <= wdata_i;
      if (frac_we_i) cnt_q[FRAC_W-1:0]     <= wdata_i[FRAC_W-1:0];
    end else if (step_i) begin
      cnt_q <= inc_w[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/srtc_alarm_unit.sv
module srtc_alarm_unit #(
  parameter int unsigned SEC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alarm_wr_i,
  input  logic [SEC_W-1:0] wdata_i,
  input  logic             roll_i,
  input  logic [SEC_W-1:0] next_sec_i,
  input  logic             clr_i,
  input  logic             ie_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o,
  output logic             irq_o,
  output logic             hit_o
);
  function automatic logic sec_match(input logic [SEC_W-1:0] a, input logic [SEC_W-1:0] b);
    return a == b;
  endfunction

  logic [SEC_W-1:0] alarm_q;
  logic             flag_q;

  assign hit_o   = roll_i & sec_match(next_sec_i, alarm_q);
  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & ie_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '1;
      flag_q  <= 1'b0;
    end else begin
      if (alarm_wr_i) alarm_q <= wdata_i;
      if (hit_o)      flag_q  <= 1'b1;
      else if (clr_i) flag_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/srtc_ctrl_regs.sv
module srtc_ctrl_regs
  import srtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              wrap_i,
  input  logic              ovf_clr_i,
  output logic              en_o,
  output logic              ie_o,
  output logic              locked_o,
  output logic              ovf_o
);
  logic en_q, ie_q, slock_q, hlock_q, ovf_q;

  assign en_o     = en_q;
  assign ie_o     = ie_q;
  assign locked_o = slock_q | hlock_q;
  assign ovf_o    = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      ie_q    <= 1'b0;
      slock_q <= 1'b0;
      hlock_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (ctrl_wr_i) begin
        if (!locked_o) en_q <= ctrl_data_i[CTRL_EN];
        ie_q    <= ctrl_data_i[CTRL_IE];
        slock_q <= slock_q | ctrl_data_i[CTRL_SLOCK];
        hlock_q <= hlock_q | ctrl_data_i[CTRL_HLOCK];
      end
      if (wrap_i)         ovf_q <= 1'b1;
      else if (ovf_clr_i) ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/secure_rtc_counter.sv
module secure_rtc_counter
  import srtc_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              nonvalid_i,
  input  logic              failure_i,
  input  logic              sec_wr_i,
  input  logic              frac_wr_i,
  input  logic              alarm_wr_i,
  input  logic              ctrl_wr_i,
  input  logic [SEC_W-1:0]  wdata_i,
  input  logic [CTRL_W-1:0] ctrl_data_i,
  input  logic              ovf_clr_i,
  input  logic              alarm_clr_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic [SEC_W-1:0]  alarm_o,
  output logic              ovf_o,
  output logic              alarm_flag_o,
  output logic              alarm_irq_o
);
  // named internal events, observed by the bound checker
  logic             en_w, ie_w, locked_w;
  logic             run_w, wr_acc_w, step_w;
  logic             wrap_w, roll_w, hit_w;
  logic [SEC_W-1:0] next_sec_w;

  assign run_w    = en_w & ~ovf_o & ~nonvalid_i & ~failure_i;
  assign wr_acc_w = (sec_wr_i | frac_wr_i) & ~locked_w;
  assign step_w   = tick_i & run_w & ~wr_acc_w;

  srtc_ctrl_regs u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_data_i (ctrl_data_i),
    .wrap_i      (wrap_w),
    .ovf_clr_i   (ovf_clr_i),
    .en_o        (en_w),
    .ie_o        (ie_w),
    .locked_o    (locked_w),
    .ovf_o       (ovf_o)
  );

  srtc_count_core #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_w),
    .sec_we_i   (sec_wr_i & ~locked_w),
    .frac_we_i  (frac_wr_i & ~locked_w),
    .wdata_i    (wdata_i),
    .sec_o      (sec_o),
    .frac_o     (frac_o),
    .wrap_o     (wrap_w),
    .roll_o     (roll_w),
    .next_sec_o (next_sec_w)
  );

  srtc_alarm_unit #(.SEC_W(SEC_W)) u_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alarm_wr_i (alarm_wr_i),
    .wdata_i    (wdata_i),
    .roll_i     (roll_w),
    .next_sec_i (next_sec_w),
    .clr_i      (alarm_clr_i),
    .ie_i       (ie_w),
    .alarm_o    (alarm_o),
    .flag_o     (alarm_flag_o),
    .irq_o      (alarm_irq_o),
    .hit_o      (hit_w)
  );
endmodule

// File: rtl/secure_rtc_counter_chk.sv
module secure_rtc_counter_chk #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SEC_W-1:0]  sec_o,
  input logic [FRAC_W-1:0] frac_o,
  input logic [SEC_W-1:0]  alarm_o,
  input logic              ovf_o,
  input logic              ovf_clr_i,
  input logic              alarm_flag_o,
  input logic              alarm_irq_o,
  input logic              ie_w,
  input logic              locked_w,
  input logic              run_w,
  input logic              wr_acc_w,
  input logic              step_w,
  input logic              wrap_w,
  input logic              hit_w
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_advance_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_w && !wrap_w |=> {sec_o, frac_o} == $past({sec_o, frac_o}) + ONE);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_w && !wr_acc_w |=> $stable(sec_o) && $stable(frac_o));

  p_lock_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_w && !step_w |=> $stable({sec_o, frac_o}));

  p_lock_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_w |=> locked_w);

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_w |=> ovf_o && sec_o == '0 && frac_o == '0);

  p_ovf_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && ovf_clr_i && !wrap_w |=> !ovf_o);

  p_irq_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_o |-> alarm_flag_o && ie_w);

  p_hit_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_w |=> alarm_flag_o);

  p_rise_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) && $stable(alarm_o) |-> sec_o == alarm_o && frac_o == '0);
endmodule

bind secure_rtc_counter secure_rtc_counter_chk #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sec_o        (sec_o),
  .frac_o       (frac_o),
  .alarm_o      (alarm_o),
  .ovf_o        (ovf_o),
  .ovf_clr_i    (ovf_clr_i),
  .alarm_flag_o (alarm_flag_o),
  .alarm_irq_o  (alarm_irq_o),
  .ie_w         (ie_w),
  .locked_w     (locked_w),
  .run_w        (run_w),
  .wr_acc_w     (wr_acc_w),
  .step_w       (step_w),
  .wrap_w       (wrap_w),
  .hit_w        (hit_w)
);

// File: tb/secure_rtc_counter_tb_top.sv
module secure_rtc_counter_tb_top;
  localparam int SW = 4;
  localparam int FW = 2;
  localparam int FMOD = 1 << FW;
  localparam int SMOD = 1 << SW;
  localparam int CMOD = FMOD * SMOD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, nv = 1'b0, fl = 1'b0;
  logic sw = 1'b0, fw = 1'b0, aw = 1'b0, cw = 1'b0, oc = 1'b0, ac = 1'b0;
  logic [SW-1:0] wdata = '0;
  logic [3:0]    cdata = '0;
  logic [SW-1:0] sec, alarm;
  logic [FW-1:0] frac;
  logic ovf, aflag, airq;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state, derived from the requirements
  int m_cnt, m_alarm;
  bit m_ovf, m_flag, m_en, m_ie, m_slock, m_hlock;

  always #10 clk = ~clk;

  secure_rtc_counter #(.SEC_W(SW), .FRAC_W(FW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .nonvalid_i(nv), .failure_i(fl),
    .sec_wr_i(sw), .frac_wr_i(fw), .alarm_wr_i(aw), .ctrl_wr_i(cw),
    .wdata_i(wdata), .ctrl_data_i(cdata), .ovf_clr_i(oc), .alarm_clr_i(ac),
    .sec_o(sec), .frac_o(frac), .alarm_o(alarm), .ovf_o(ovf),
    .alarm_flag_o(aflag), .alarm_irq_o(airq));

  task automatic cmp(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "sec", int'(sec), m_cnt / FMOD);
    cmp(tag, "frac", int'(frac), m_cnt % FMOD);
    cmp(tag, "alarm", int'(alarm), m_alarm);
    cmp(tag, "ovf", int'(ovf), int'(m_ovf));
    cmp(tag, "flag", int'(aflag), int'(m_flag));
    cmp(tag, "irq", int'(airq), int'(m_flag & m_ie));
  endtask

  task automatic model_reset();
    m_cnt = 0; m_alarm = SMOD - 1;
    m_ovf = 0; m_flag = 0; m_en = 0; m_ie = 0; m_slock = 0; m_hlock = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
  endtask

  // one clock cycle of stimulus; model updated, outputs checked at the next falling edge
  task automatic step(input bit t, input bit s, input bit f, input bit a, input bit c,
                      input int data, input bit o, input bit al, input string tag);
    bit locked, run, acc, hit, wrapped;
    int n;
    locked = m_slock | m_hlock;
    run = m_en & !m_ovf & !nv & !fl;
    acc = (s | f) & !locked;
    hit = 0; wrapped = 0;
    n = m_cnt;
    if (acc) begin
      if (s) n = (data % SMOD) * FMOD + (n % FMOD);
      if (f) n = (n / FMOD) * FMOD + (data % FMOD);
    end else if (t && run) begin
      n = (m_cnt + 1) % CMOD;
      wrapped = (m_cnt == CMOD - 1);
      hit = (n % FMOD == 0) && (n / FMOD == m_alarm);
    end
    if (hit) m_flag = 1; else if (al) m_flag = 0;
    if (wrapped) m_ovf = 1; else if (o) m_ovf = 0;
    if (c) begin
      if (!locked) m_en = (data >> 0) & 1;
      m_ie = (data >> 1) & 1;
      m_slock |= (data >> 2) & 1;
      m_hlock |= (data >> 3) & 1;
    end
    if (a) m_alarm = data % SMOD;
    m_cnt = n;
    tick = t; sw = s; fw = f; aw = a; cw = c; oc = o; ac = al;
    wdata = SW'(data); cdata = 4'(data);
    @(negedge clk);
    tick = 0; sw = 0; fw = 0; aw = 0; cw = 0; oc = 0; ac = 0;
    check_all(tag);
  endtask

  task automatic ticks(input int k, input string tag);
    for (int i = 0; i < k; i++) step(1, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R2");

    // disabled: ticks do nothing (R5)
    ticks(3, "R5");
    step(0, 0, 0, 0, 1, 1, 0, 0, "R5");

    // full sweep of the count for every alarm value: R1, R8, R9, R4, R7
    for (int a = 0; a < SMOD; a++) begin
      if (a == SMOD / 2) step(0, 0, 0, 0, 1, 3, 0, 0, "R4");
      step(0, 0, 0, 1, 0, a, 0, 0, "R10");
      step(0, 1, 0, 0, 0, 0, 0, 0, "R3");
      step(0, 0, 1, 0, 0, 0, 0, 0, "R3");
      ticks(CMOD + 3, "R1_R8_R9");
      step(0, 0, 0, 0, 0, 0, 1, 0, "R7");
      step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
      ticks(2, "R7");
    end

    // freezes (R5)
    step(0, 1, 0, 0, 0, 3, 0, 0, "R3");
    nv = 1; ticks(4, "R5"); nv = 0;
    fl = 1; ticks(4, "R5"); fl = 0;
    step(0, 0, 0, 0, 1, 2, 0, 0, "R5");
    ticks(3, "R5");
    step(0, 0, 0, 0, 1, 3, 0, 0, "R5");
    ticks(2, "R1");

    // writes beat a tick in the same cycle; all seconds values (R3)
    for (int v = 0; v < SMOD; v++) begin
      step(1, 1, 0, 0, 0, v, 0, 0, "R3");
      step(1, 0, 1, 0, 0, v, 0, 0, "R3");
      ticks(1, "R1");
    end

    // set beats clear, and alarm write while matching uses old alarm (R9, R10)
    step(0, 0, 0, 1, 0, 5, 0, 0, "R10");
    step(0, 1, 0, 0, 0, 4, 0, 0, "R3");
    step(0, 0, 1, 0, 0, 3, 0, 0, "R3");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(1, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9");
    step(0, 0, 1, 0, 0, 3, 0, 0, "R3");
    step(1, 0, 0, 1, 0, 9, 0, 0, "R10");

    // soft lock (R6)
    step(0, 0, 0, 0, 1, 7, 0, 0, "R6");
    step(1, 1, 0, 0, 0, 1, 0, 0, "R6");
    step(1, 0, 1, 0, 0, 2, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6");
    ticks(3, "R6");
    step(0, 0, 0, 1, 0, 2, 0, 0, "R10");

    // hard lock after reset (R6)
    do_reset();
    check_all("R2");
    step(0, 0, 0, 0, 1, 9, 0, 0, "R6");
    step(0, 1, 0, 0, 0, 7, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R6");
    ticks(5, "R6");
    step(0, 0, 0, 0, 1, 4, 0, 0, "R6");
    ticks(2, "R6");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule